// File: doc/BRIEF.md
# Two-Level Interrupt Status Register Bank

This block holds an 8-bit interrupt status register and a matching 8-bit enable register behind a small processor read/write port, for use inside a packet bridge. Four of the status fields are sticky flags raised by single-cycle event pulses. Two of them say that a captured buffer is ready to be read, one for each traffic direction. The other two say that an insertion buffer is ready to be written, again one for each direction. Software clears these flags by writing ones to them. The fifth field reflects a performance-monitor condition. It follows its source and cannot be cleared by software.

The bank is the second level of a two-level interrupt tree. Its status is only visible, on reads and on the interrupt output, while the matching first-level field (the `lvl1_act` input) is asserted. The enabled status bits are ORed into a single registered request, `irq`, which feeds the first-level register outside this block.

Top module: `irq_evt_regbank`

## Requirements
- R1: After reset, every status and enable bit is 0, `irq` is 0 and `bus_rdata` is 0.
- R2: A one-cycle pulse on `sticky_evt[i]` sets status bit i on the next clock edge, and the bit stays set. The mapping is: bit 0 is capture-ready for direction A, bit 1 is capture-ready for direction B, bit 2 is insert-ready for direction A, and bit 3 is insert-ready for direction B.
- R3: A write to the status address clears each of bits 3:0 whose write-data bit is 1 and leaves unchanged each bit whose write-data bit is 0.
- R4: Status bit 4 (monitor) equals `mon_src` as registered on the previous clock edge. A write to the status address has no effect on it.
- R5: When an event pulse and a clearing write reach the same sticky bit in the same cycle, the bit ends up set.
- R6: The enable register at address 1 reads back what was last written to bits 4:0. Bits 7:5 of both registers always read 0, and writes to them are ignored.
- R7: `irq` is 1 exactly when, one cycle earlier, some bit in 4:0 was set in both the status and the enable register while `lvl1_act` was 1.
- R8: While `lvl1_act` is 0, status reads return 0 and `irq` falls on the next cycle. The latched sticky bits are kept, and they reappear once `lvl1_act` returns to 1.
- R9: The status register is at address 0 and the enable register is at address 1. Read data is valid on the cycle after the read strobe. A read of any other address returns 0. `bus_rdata` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lvl1_act | input | 1 | First-level field for this bank is active |
| sticky_evt | input | 4 | Event pulses for the capture and insert flags |
| mon_src | input | 1 | Monitor event level |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the strobe |
| irq | output | 1 | Registered interrupt request to the first level |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 2-bit address and a two-stage reset synchronizer. With a 2-bit address, the two unmapped addresses can be reached, so the zero-return read path is tested. With 8-bit data and only five fields, the three reserved upper bits can be driven and checked on both registers.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
  // Field positions shared by the status and enable registers.
  localparam int FLD_CAP_A  = 0;
  localparam int FLD_CAP_B  = 1;
  localparam int FLD_INS_A  = 2;
  localparam int FLD_INS_B  = 3;
  localparam int FLD_MON    = 4;
  localparam int NUM_STICKY = 4;
  localparam int NUM_FLD    = 5;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_ENA  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int SYNC_STG = 2
) (
  input  logic clk,
  input  logic arst_ni,
  output logic rst_no
);
  logic [SYNC_STG-1:0] sr_q;
  logic [SYNC_STG-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[SYNC_STG-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_ni) begin
    if (!arst_ni) sr_q <= '0;
    else          sr_q <= sr_d;
  end

  assign rst_no = sr_q[SYNC_STG-1];
endmodule

// File: rtl/irq_stat_cell.sv
// One status bit: sticky write-one-to-clear, or a level that follows its source.
module irq_stat_cell #(
  parameter bit IS_MON = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic src_i,
  output logic q_o
);
  logic q_d;
  logic q_en;

  generate
    if (IS_MON) begin : g_mon
      always_comb begin
        q_en = 1'b1;
        q_d  = src_i;
      end
    end else begin : g_sticky
      always_comb begin
        q_en = set_i | clr_i;
        q_d  = set_i | (q_o & ~clr_i);  // event wins over clear
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= 1'b0;
    else if (q_en) q_o <= q_d;
  end
endmodule

// File: rtl/irq_bus_ctl.sv
module irq_bus_ctl
  import irq_evt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = '0,
  parameter logic [ADDR_W-1:0] ENA_ADDR  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [NUM_FLD-1:0] stat_vis,
  output logic [NUM_FLD-1:0] stat_clr,
  output logic [NUM_FLD-1:0] ena_q,
  output logic [DATA_W-1:0]  bus_rdata
);
  localparam int PAD_W = DATA_W - NUM_FLD;

  reg_sel_e            sel;
  logic [NUM_FLD-1:0]  ena_d;
  logic                ena_en;
  logic [DATA_W-1:0]   rdata_d;

  always_comb begin
    if (bus_addr == STAT_ADDR)     sel = SEL_STAT;
    else if (bus_addr == ENA_ADDR) sel = SEL_ENA;
    else                           sel = SEL_NONE;
  end

  always_comb begin
    stat_clr = (bus_wr && sel == SEL_STAT) ? bus_wdata[NUM_FLD-1:0] : '0;
    ena_en   = bus_wr && sel == SEL_ENA;
    ena_d    = bus_wdata[NUM_FLD-1:0];
  end

  always_comb begin
    unique case (sel)
      SEL_STAT: rdata_d = {{PAD_W{1'b0}}, stat_vis};
      SEL_ENA:  rdata_d = {{PAD_W{1'b0}}, ena_q};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ena_q <= '0;
    else if (ena_en) ena_q <= ena_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rdata_d;
  end
endmodule

// File: rtl/irq_evt_regbank.sv
module irq_evt_regbank
  import irq_evt_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int SYNC_STG = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = '0,
  parameter logic [ADDR_W-1:0] ENA_ADDR  = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lvl1_act,
  input  logic [NUM_STICKY-1:0] sticky_evt,
  input  logic                  mon_src,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  irq
);
  logic               rst_sync_n;
  logic [NUM_FLD-1:0] stat_q;
  logic [NUM_FLD-1:0] stat_vis;
  logic [NUM_FLD-1:0] stat_clr;
  logic [NUM_FLD-1:0] ena_q;
  logic               irq_d;

  irq_rst_sync #(.SYNC_STG(SYNC_STG)) u_rst (
    .clk(clk), .arst_ni(rst_n), .rst_no(rst_sync_n)
  );

  generate
    for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
      if (i == FLD_MON) begin : g_m
        irq_stat_cell #(.IS_MON(1'b1)) u_cell (
          .clk(clk), .rst_n(rst_sync_n), .set_i(1'b0), .clr_i(1'b0),
          .src_i(mon_src), .q_o(stat_q[i])
        );
      end else begin : g_s
        irq_stat_cell #(.IS_MON(1'b0)) u_cell (
          .clk(clk), .rst_n(rst_sync_n), .set_i(sticky_evt[i]),
          .clr_i(stat_clr[i]), .src_i(1'b0), .q_o(stat_q[i])
        );
      end
    end
  endgenerate

  always_comb begin
    stat_vis = stat_q & {NUM_FLD{lvl1_act}};
    irq_d    = |(stat_vis & ena_q);
  end

  irq_bus_ctl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .ENA_ADDR(ENA_ADDR)
  ) u_bus (
    .clk(clk), .rst_n(rst_sync_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stat_vis(stat_vis),
    .stat_clr(stat_clr), .ena_q(ena_q), .bus_rdata(bus_rdata)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq <= 1'b0;
    else             irq <= irq_d;
  end
endmodule

// File: rtl/irq_evt_regbank_chk.sv
module irq_evt_regbank_chk
  import irq_evt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = '0
) (
  input logic                  clk,
  input logic                  rst_ni,
  input logic                  lvl1_act,
  input logic [NUM_STICKY-1:0] sticky_evt,
  input logic                  mon_src,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic                  irq,
  input logic [NUM_FLD-1:0]    stat_q,
  input logic [NUM_FLD-1:0]    ena_q
);
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (|sticky_evt) |=> ((stat_q[NUM_STICKY-1:0] & $past(sticky_evt)) == $past(sticky_evt)));

  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    !(bus_wr && bus_addr == STAT_ADDR) |=>
      ((stat_q[NUM_STICKY-1:0] & $past(stat_q[NUM_STICKY-1:0])) == $past(stat_q[NUM_STICKY-1:0])));

  assert_mon_follow_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> (stat_q[FLD_MON] == $past(mon_src)));

  assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_rdata[DATA_W-1:NUM_FLD] == '0);

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> $past(lvl1_act && |(stat_q & ena_q)));

  assert_lvl1_mask_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    !lvl1_act |=> !irq);

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind irq_evt_regbank irq_evt_regbank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rst_ni(rst_sync_n), .lvl1_act(lvl1_act), .sticky_evt(sticky_evt),
  .mon_src(mon_src), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq(irq), .stat_q(stat_q), .ena_q(ena_q)
);

// File: tb/irq_evt_regbank_tb.sv
`timescale 1ns/1ps
module irq_evt_regbank_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       lvl1_act;
  logic [3:0] sticky_evt;
  logic       mon_src;
  logic       bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  irq_evt_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .lvl1_act(lvl1_act), .sticky_evt(sticky_evt),
    .mon_src(mon_src), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_evt(input logic [3:0] m);
    @(negedge clk);
    sticky_evt = m;
    @(negedge clk);
    sticky_evt = 4'h0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 rdata", bus_rdata, 8'h00);
    bus_read(2'd0, d); chk("R1 status", d, 8'h00);
    bus_read(2'd1, d); chk("R1 enable", d, 8'h00);
  endtask

  task automatic t_sticky_set();
    logic [7:0] d;
    pulse_evt(4'b0101);
    repeat (3) @(negedge clk);
    bus_read(2'd0, d); chk("R2 set bits 0,2", d, 8'h05);
    pulse_evt(4'b1010);
    bus_read(2'd0, d); chk("R2 set all sticky", d, 8'h0F);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    bus_write(2'd0, 8'h00);
    bus_read(2'd0, d); chk("R3 zero write keeps", d, 8'h0F);
    bus_write(2'd0, 8'h06);
    bus_read(2'd0, d); chk("R3 clear 1,2", d, 8'h09);
    bus_write(2'd0, 8'hFF);
    bus_read(2'd0, d); chk("R3 clear all", d, 8'h00);
  endtask

  task automatic t_mon();
    logic [7:0] d;
    @(negedge clk); mon_src = 1'b1;
    bus_read(2'd0, d); chk("R4 mon follows", d, 8'h10);
    bus_write(2'd0, 8'h10);
    bus_read(2'd0, d); chk("R4 write no effect", d, 8'h10);
    @(negedge clk); mon_src = 1'b0;
    bus_read(2'd0, d); chk("R4 mon drops with source", d, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    pulse_evt(4'b0001);
    @(negedge clk);
    sticky_evt = 4'b0010; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h03;
    @(negedge clk);
    sticky_evt = 4'b0000; bus_wr = 1'b0; bus_wdata = 8'h00;
    bus_read(2'd0, d); chk("R5 event wins, other cleared", d, 8'h02);
    bus_write(2'd0, 8'h02);
  endtask

  task automatic t_enable_rsvd();
    logic [7:0] d;
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, d); chk("R6 enable rsvd masked", d, 8'h1F);
    bus_write(2'd1, 8'h0A);
    bus_read(2'd1, d); chk("R6 enable readback", d, 8'h0A);
    bus_write(2'd0, 8'hE0);
    bus_read(2'd0, d); chk("R6 status rsvd zero", d, 8'h00);
    bus_write(2'd1, 8'h00);
  endtask

  task automatic t_irq();
    bus_write(2'd1, 8'h01);
    pulse_evt(4'b0010);
    @(negedge clk); chk("R7 disabled bit no irq", {7'd0, irq}, 8'h00);
    pulse_evt(4'b0001);
    chk("R7 irq one cycle after status", {7'd0, irq}, 8'h00);
    @(negedge clk); chk("R7 irq set", {7'd0, irq}, 8'h01);
    bus_write(2'd1, 8'h00);
    @(negedge clk); chk("R7 irq drops when disabled", {7'd0, irq}, 8'h00);
    bus_write(2'd1, 8'h01);
    @(negedge clk); chk("R7 irq returns", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_lvl1();
    logic [7:0] d;
    @(negedge clk); lvl1_act = 1'b0;
    @(negedge clk); chk("R8 irq masked", {7'd0, irq}, 8'h00);
    bus_read(2'd0, d); chk("R8 status hidden", d, 8'h00);
    @(negedge clk); lvl1_act = 1'b1;
    bus_read(2'd0, d); chk("R8 bits retained", d, 8'h03);
    chk("R8 irq back", {7'd0, irq}, 8'h01);
    bus_write(2'd0, 8'h03);
    bus_write(2'd1, 8'h00);
  endtask

  task automatic t_read_path();
    logic [7:0] d;
    bus_write(2'd1, 8'h15);
    bus_read(2'd2, d); chk("R9 unmapped 2", d, 8'h00);
    bus_read(2'd1, d); chk("R9 enable at 1", d, 8'h15);
    bus_read(2'd3, d); chk("R9 unmapped 3", d, 8'h00);
    bus_read(2'd1, d);
    pulse_evt(4'b0100);
    bus_write(2'd1, 8'h00);
    @(negedge clk); chk("R9 rdata holds", bus_rdata, 8'h15);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 2'd0;
    chk("R9 not yet updated", bus_rdata, 8'h15);
    @(negedge clk); bus_rd = 1'b0;
    chk("R9 data next cycle", bus_rdata, 8'h04);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lvl1_act = 1'b1; sticky_evt = 4'h0; mon_src = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sticky_set();
    t_w1c();
    t_mon();
    t_collision();
    t_enable_rsvd();
    t_irq();
    t_lvl1();
    t_read_path();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule